// File: doc/BRIEF.md
# Prioritized Core Event Controller

This block sits between a processor core and sixteen event request lines. Each line has a fixed priority level. Level 0 is the most urgent and level 15 the least. A request that is high at a clock edge is remembered in a pending register. A per-level enable register decides which pending levels may be handed to the core. The block presents the most urgent pending, enabled level as a 4-bit vector index together with a valid flag. When the core acknowledges that index, the pending bit for it is cleared.

The levels are assigned as follows:

| Levels | Use |
|---|---|
| 0 | emulation |
| 1 | reset |
| 2 | non-maskable interrupt |
| 3 | exception |
| 4 | reserved |
| 5 | hardware error |
| 6 | core timer |
| 7 to 15 | general purpose |

Levels 14 and 15 are meant for software: a register write can raise them. Levels 0 to 2 cannot be blocked. A blocked level keeps its pending bit, so it is serviced as soon as it is enabled. Software can cancel a pending request, but only on a level that is currently blocked.

A small 32-bit register port with a privilege input gives access to the pending and enable registers and to a raise register. Unprivileged accesses have no effect on state and are reported through an error flag.

Top module: `evt_core_ctrl`

## Requirements
- R1: After reset the pending bits are all 0, `vec_vld` is 0, `reg_rdata` is 0 and `reg_err` is 0. The enable register then reads 0x0000_0007.
- R2: A request line that is high at a rising clock edge sets its pending bit. Address 0 reads the pending bits on data bits [15:0], with bit n standing for level n.
- R3: `vec_vld`/`vec_idx` show the lowest-numbered level whose pending bit and effective enable bit are both 1. With no such level, `vec_vld` is 0. The output follows the pending and enable registers with one clock of delay.
- R4: A pending level with a cleared enable bit is not presented but stays pending. It is presented once its enable bit is set.
- R5: Levels 0, 1 and 2 are always enabled. Their enable bits read as 1 whatever was written.
- R6: Level 4 never becomes pending. Its bit reads 0 in both the pending and the enable register.
- R7: `vec_ack` while `vec_vld` is 1 clears the pending bit of `vec_idx`. If the same level's request line is high in that cycle, the bit stays set.
- R8: A privileged write to address 0 clears every pending bit whose data bit is 1 and whose effective enable bit is 0. Pending bits of enabled levels, and of levels 0 to 2, are left alone.
- R9: A privileged write to address 2 sets the pending bits of levels 14 and 15 where data bits 14 and 15 are 1. All other data bits have no effect, and address 2 reads 0.
- R10: A privileged write to address 1 loads the enable register from data bits [15:0]. Read data bits [31:16] are always 0, and address 3 reads 0 and ignores writes.
- R11: An access with `reg_priv` low changes no register. If it is a read, it returns 0. Either way, `reg_err` is 1 in the following cycle. Privileged accesses leave `reg_err` at 0.
- R12: Read data appears on `reg_rdata` one clock after the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_req | input | 16 | Event request lines, index = priority level |
| vec_vld | output | 1 | A serviceable event is presented |
| vec_idx | output | 4 | Level of the presented event |
| vec_ack | input | 1 | Core accepts the presented event |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_priv | input | 1 | Access is privileged |
| reg_addr | input | 2 | 0 pending, 1 enable, 2 raise, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_err | output | 1 | Previous access was unprivileged |

## Verification
The hardest situation to reach is a single cycle in which one level is hit by several things at once. Its request line, an acknowledge, a software cancel and an enable change can all land together, and on a level that is masked at that moment. Only then do the set-wins rule and the masked-only cancel rule interact.

Sparse random requests, random register operations and acknowledges are mixed every cycle so that such collisions occur. A cycle-exact bench model predicts the vector, read data and error flag each cycle. Directed steps cover the re-latch on acknowledge, cancel of a masked level and the unblockable levels.

// File: rtl/evt_ctrl_pkg.sv
package evt_ctrl_pkg;
  localparam int unsigned EVT_N     = 16;
  localparam int unsigned EVT_IDX_W = $clog2(EVT_N);
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned ADDR_W    = 2;

  // levels that bypass the enable register
  localparam logic [EVT_N-1:0] LVL_FORCED  = 16'h0007;
  // level that never latches
  localparam logic [EVT_N-1:0] LVL_RSVD    = 16'h0010;
  // levels software may raise
  localparam logic [EVT_N-1:0] LVL_SWRAISE = 16'hC000;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PEND  = 2'd0,
    SEL_ENAB  = 2'd1,
    SEL_RAISE = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_reg_if.sv
module evt_reg_if
  import evt_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic              acc_priv_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [BUS_W-1:0]  acc_wdata_i,
  input  logic [EVT_N-1:0]  pend_i,
  input  logic [EVT_N-1:0]  en_eff_i,
  output logic [EVT_N-1:0]  clr_req_o,
  output logic [EVT_N-1:0]  raise_o,
  output logic              en_wr_o,
  output logic [EVT_N-1:0]  en_wdata_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              err_o
);
  localparam int unsigned PAD_W = BUS_W - EVT_N;

  reg_sel_e         sel;
  logic             wr_ok;
  logic             rd_any;
  logic [EVT_N-1:0] wlo;
  logic [BUS_W-1:0] rdata_n;
  logic             rdata_ce;
  logic             err_n;
  logic             unused_whi;

  assign sel        = reg_sel_e'(acc_addr_i);
  assign wlo        = acc_wdata_i[EVT_N-1:0];
  assign unused_whi = ^acc_wdata_i[BUS_W-1:EVT_N];

  always_comb begin
    wr_ok      = acc_en_i & acc_wr_i & acc_priv_i;
    rd_any     = acc_en_i & ~acc_wr_i;
    clr_req_o  = (wr_ok && sel == SEL_PEND)  ? wlo : '0;
    raise_o    = (wr_ok && sel == SEL_RAISE) ? (wlo & LVL_SWRAISE) : '0;
    en_wr_o    = wr_ok && sel == SEL_ENAB;
    en_wdata_o = wlo;
    rdata_n    = '0;
    if (acc_priv_i) begin
      unique case (sel)
        SEL_PEND: rdata_n = {{PAD_W{1'b0}}, pend_i};
        SEL_ENAB: rdata_n = {{PAD_W{1'b0}}, en_eff_i};
        default:  rdata_n = '0;
      endcase
    end
    rdata_ce = rd_any;
    err_n    = acc_en_i & ~acc_priv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rdata_ce) rdata_o <= rdata_n;
      err_o <= err_n;
    end
  end

  AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && !acc_priv_i) |=> err_o); // R11
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en_i && !acc_wr_i) |=> $stable(rdata_o)); // R12
  AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && !acc_wr_i) |=> rdata_o[BUS_W-1:EVT_N] == '0); // R10
endmodule

// File: rtl/evt_enable.sv
module evt_enable
  import evt_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr_i,
  input  logic [EVT_N-1:0] en_wdata_i,
  output logic [EVT_N-1:0] en_eff_o
);
  logic [EVT_N-1:0] en_q;
  logic [EVT_N-1:0] en_n;

  always_comb begin
    en_n     = en_wdata_i;
    en_eff_o = (en_q | LVL_FORCED) & ~LVL_RSVD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= en_n;
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_eff_o)); // R10
endmodule

// File: rtl/evt_pending.sv
module evt_pending
  import evt_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EVT_N-1:0]     req_i,
  input  logic [EVT_N-1:0]     raise_i,
  input  logic [EVT_N-1:0]     clr_req_i,
  input  logic [EVT_N-1:0]     en_eff_i,
  input  logic                 ack_vld_i,
  input  logic [EVT_IDX_W-1:0] ack_idx_i,
  output logic [EVT_N-1:0]     pend_q
);
  logic [EVT_N-1:0] ack_clr;
  logic [EVT_N-1:0] sw_clr;
  logic [EVT_N-1:0] pend_n;
  logic             pend_ce;

  always_comb begin
    ack_clr = '0;
    if (ack_vld_i) ack_clr[ack_idx_i] = 1'b1;
    sw_clr  = clr_req_i & ~en_eff_i & ~LVL_FORCED;
    pend_n  = ((pend_q & ~ack_clr & ~sw_clr) | req_i | raise_i) & ~LVL_RSVD;
    pend_ce = pend_n != pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ce) pend_q <= pend_n;
  end

  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[4]); // R6
  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(req_i) & ~LVL_RSVD) & ~pend_q) == '0)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld_i && !req_i[ack_idx_i] && !raise_i[ack_idx_i])
    |=> ((pend_q >> $past(ack_idx_i)) & EVT_N'(1)) == '0); // R7
  AST_ENABLED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q & en_eff_i) & ~$past(ack_clr) & ~pend_q) == '0)); // R8
endmodule

// File: rtl/evt_prio_sel.sv
module evt_prio_sel
  import evt_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EVT_N-1:0]     pend_i,
  input  logic [EVT_N-1:0]     en_eff_i,
  output logic                 vec_vld_o,
  output logic [EVT_IDX_W-1:0] vec_idx_o
);
  logic [EVT_N-1:0]     cand;
  logic                 sel_vld;
  logic [EVT_IDX_W-1:0] sel_idx;
  logic                 vec_ce;

  always_comb begin
    cand    = pend_i & en_eff_i;
    sel_vld = 1'b0;
    sel_idx = '0;
    for (int i = EVT_N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        sel_vld = 1'b1;
        sel_idx = i[EVT_IDX_W-1:0];
      end
    end
    vec_ce = (sel_vld != vec_vld_o) || (sel_idx != vec_idx_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_vld_o <= 1'b0;
      vec_idx_o <= '0;
    end else if (vec_ce) begin
      vec_vld_o <= sel_vld;
      vec_idx_o <= sel_idx;
    end
  end

  AST_VEC_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> ((($past(cand) >> vec_idx_o) & EVT_N'(1)) == EVT_N'(1))); // R3
  AST_VEC_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> (($past(cand) & ((EVT_N'(1) << vec_idx_o) - EVT_N'(1))) == '0)); // R3
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_vld_o |-> ($past(cand) == '0)); // R3
endmodule

// File: rtl/evt_core_ctrl.sv
module evt_core_ctrl
  import evt_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EVT_N-1:0]     evt_req,
  output logic                 vec_vld,
  output logic [EVT_IDX_W-1:0] vec_idx,
  input  logic                 vec_ack,
  input  logic                 reg_en,
  input  logic                 reg_wr,
  input  logic                 reg_priv,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [BUS_W-1:0]     reg_wdata,
  output logic [BUS_W-1:0]     reg_rdata,
  output logic                 reg_err
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [EVT_N-1:0] pend_q;
  logic [EVT_N-1:0] en_eff;
  logic [EVT_N-1:0] clr_req;
  logic [EVT_N-1:0] raise;
  logic             en_wr;
  logic [EVT_N-1:0] en_wdata;
  logic             ack_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ack_vld = vec_ack & vec_vld;

  evt_reg_if i_reg_if (
    .clk(clk), .rst_n(rst_int_n),
    .acc_en_i(reg_en), .acc_wr_i(reg_wr), .acc_priv_i(reg_priv),
    .acc_addr_i(reg_addr), .acc_wdata_i(reg_wdata),
    .pend_i(pend_q), .en_eff_i(en_eff),
    .clr_req_o(clr_req), .raise_o(raise),
    .en_wr_o(en_wr), .en_wdata_o(en_wdata),
    .rdata_o(reg_rdata), .err_o(reg_err)
  );

  evt_enable i_enable (
    .clk(clk), .rst_n(rst_int_n),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata), .en_eff_o(en_eff)
  );

  evt_pending i_pending (
    .clk(clk), .rst_n(rst_int_n),
    .req_i(evt_req), .raise_i(raise), .clr_req_i(clr_req),
    .en_eff_i(en_eff), .ack_vld_i(ack_vld), .ack_idx_i(vec_idx),
    .pend_q(pend_q)
  );

  evt_prio_sel i_prio_sel (
    .clk(clk), .rst_n(rst_int_n),
    .pend_i(pend_q), .en_eff_i(en_eff),
    .vec_vld_o(vec_vld), .vec_idx_o(vec_idx)
  );

  AST_NOPRIV_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_en && !reg_priv) |=> $stable(en_eff)); // R11
  AST_FORCED_LEVELS: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_en |=> ((en_eff & LVL_FORCED) == LVL_FORCED)); // R5
  AST_SW_RAISE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_en && reg_wr && reg_priv && reg_addr == 2'd2 && reg_wdata[15]) |=> pend_q[15]); // R9
endmodule

// File: tb/test_evt_core_ctrl.sv
`timescale 1ns/1ps
module test_evt_core_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt_req;
  logic        vec_vld;
  logic [3:0]  vec_idx;
  logic        vec_ack;
  logic        reg_en, reg_wr, reg_priv;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] mp, mp_prev, men, men_prev;
  logic [31:0] m_rdata;
  logic        m_err;

  always #5 clk = ~clk;

  evt_core_ctrl i_evt_core_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_req(evt_req),
    .vec_vld(vec_vld), .vec_idx(vec_idx), .vec_ack(vec_ack),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_priv(reg_priv),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err)
  );

  function automatic logic [15:0] en_eff_f(input logic [15:0] q);
    return (q | 16'h0007) & ~16'h0010;
  endfunction

  function automatic logic [4:0] pick(input logic [15:0] c);
    for (int i = 0; i < 16; i++) if (c[i]) return {1'b1, 4'(i)};
    return 5'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic cyc(input logic [15:0] req, input bit en, input bit wr, input bit priv,
                     input logic [1:0] addr, input logic [31:0] wd, input bit ack);
    logic [4:0]  e;
    logic [15:0] ackm, clr, rse, nxt, eff;
    e = pick(mp_prev & en_eff_f(men_prev));
    chk("R3 vector", {27'd0, vec_vld, vec_idx}, {27'd0, e});
    chk("R12 read data", reg_rdata, m_rdata);
    chk("R11 error flag", {31'd0, reg_err}, {31'd0, m_err});
    evt_req = req; reg_en = en; reg_wr = wr; reg_priv = priv;
    reg_addr = addr; reg_wdata = wd; vec_ack = ack;
    eff  = en_eff_f(men);
    ackm = (ack && e[4]) ? (16'd1 << e[3:0]) : 16'd0;
    clr  = (en && wr && priv && addr == 2'd0) ? (wd[15:0] & ~eff & 16'hFFF8) : 16'd0;
    rse  = (en && wr && priv && addr == 2'd2) ? (wd[15:0] & 16'hC000) : 16'd0;
    nxt  = ((mp & ~ackm & ~clr) | req | rse) & ~16'h0010;
    @(posedge clk);
    if (en && !wr) begin
      if (!priv) m_rdata = 32'd0;
      else if (addr == 2'd0) m_rdata = {16'd0, mp};
      else if (addr == 2'd1) m_rdata = {16'd0, eff};
      else m_rdata = 32'd0;
    end
    m_err = en && !priv;
    mp_prev = mp; men_prev = men;
    mp = nxt;
    if (en && wr && priv && addr == 2'd1) men = wd[15:0];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(16'd0, 0, 0, 1, 2'd0, 32'd0, 0);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    cyc(16'd0, 1, 1, 1, a, d, 0);
  endtask

  task automatic rchk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cyc(16'd0, 1, 0, 1, a, 32'd0, 0);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    evt_req = '0; vec_ack = 0; reg_en = 0; reg_wr = 0; reg_priv = 0;
    reg_addr = '0; reg_wdata = '0;
    mp = '0; mp_prev = '0; men = '0; men_prev = '0; m_rdata = '0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    chk("R1 vec_vld after reset", {31'd0, vec_vld}, 32'd0);
    chk("R1 reg_err after reset", {31'd0, reg_err}, 32'd0);
    rchk(2'd1, 32'h0000_0007, "R1 enable reset value");
    rchk(2'd0, 32'h0000_0000, "R1 pending reset value");

    // R2, R6, R4 latch with everything maskable disabled
    cyc(16'h0030, 0, 0, 1, 2'd0, 32'd0, 0);
    idle(2);
    rchk(2'd0, 32'h0000_0020, "R2 R6 pending after requests on 4 and 5");
    chk("R4 masked level not presented", {31'd0, vec_vld}, 32'd0);

    // R10 enable all, R6 bit 4 reads 0, R4 served once enabled
    wreg(2'd1, 32'hFFFF_FFFF);
    rchk(2'd1, 32'h0000_FFEF, "R10 R6 enable readback");
    idle(1);
    chk("R4 level 5 presented after enable", {27'd0, vec_vld, vec_idx}, {27'd0, 1'b1, 4'd5});

    // R7 acknowledge
    cyc(16'd0, 0, 0, 1, 2'd0, 32'd0, 1);
    idle(1);
    chk("R7 nothing presented after ack", {31'd0, vec_vld}, 32'd0);
    rchk(2'd0, 32'h0, "R7 pending cleared by ack");

    // R5 and R8 on an unblockable level
    wreg(2'd1, 32'h0);
    cyc(16'h0004, 0, 0, 1, 2'd0, 32'd0, 0);
    idle(1);
    chk("R5 level 2 presented with enable cleared", {27'd0, vec_vld, vec_idx}, {27'd0, 1'b1, 4'd2});
    wreg(2'd0, 32'h0000_0004);
    rchk(2'd0, 32'h0000_0004, "R8 level 2 cannot be cancelled");
    cyc(16'd0, 0, 0, 1, 2'd0, 32'd0, 1);
    idle(2);

    // R8 masked cancel vs enabled keep
    cyc(16'h0200, 0, 0, 1, 2'd0, 32'd0, 0);
    wreg(2'd0, 32'h0000_FFFF);
    rchk(2'd0, 32'h0, "R8 masked level cancelled");
    wreg(2'd1, 32'h0000_0200);
    cyc(16'h0200, 0, 0, 1, 2'd0, 32'd0, 0);
    wreg(2'd0, 32'h0000_0200);
    rchk(2'd0, 32'h0000_0200, "R8 enabled level kept");
    cyc(16'd0, 0, 0, 1, 2'd0, 32'd0, 1);
    idle(2);

    // R9 software raise
    wreg(2'd1, 32'h0);
    wreg(2'd2, 32'hFFFF_FFFF);
    rchk(2'd0, 32'h0000_C000, "R9 raise sets only 14 and 15");
    rchk(2'd2, 32'h0, "R9 raise register reads zero");
    wreg(2'd0, 32'h0000_FFFF);
    rchk(2'd0, 32'h0, "R8 raised levels cancelled while masked");

    // R11 unprivileged access
    cyc(16'd0, 1, 1, 0, 2'd1, 32'hFFFF_FFFF, 0);
    chk("R11 error after unprivileged write", {31'd0, reg_err}, 32'd1);
    rchk(2'd1, 32'h0000_0007, "R11 unprivileged write ignored");
    chk("R11 no error on privileged read", {31'd0, reg_err}, 32'd0);
    cyc(16'd0, 1, 0, 0, 2'd1, 32'd0, 0);
    chk("R11 unprivileged read returns zero", reg_rdata, 32'd0);

    // R10 unused address
    wreg(2'd3, 32'hFFFF_FFFF);
    rchk(2'd3, 32'h0, "R10 address 3 reads zero");
    rchk(2'd1, 32'h0000_0007, "R10 address 3 write ignored");

    // R7 re-latch when request coincides with ack
    wreg(2'd1, 32'h0000_FFFF);
    cyc(16'h0800, 0, 0, 1, 2'd0, 32'd0, 0);
    idle(2);
    chk("R3 level 11 presented", {27'd0, vec_vld, vec_idx}, {27'd0, 1'b1, 4'd11});
    cyc(16'h0800, 0, 0, 1, 2'd0, 32'd0, 1);
    idle(1);
    rchk(2'd0, 32'h0000_0800, "R7 request wins over ack");
    idle(2);
    chk("R12 read data held", reg_rdata, 32'h0000_0800);
    cyc(16'd0, 0, 0, 1, 2'd0, 32'd0, 1);
    idle(2);

    // R3 priority among several
    cyc(16'h8421, 0, 0, 1, 2'd0, 32'd0, 0);
    idle(1);
    chk("R3 level 0 first", {27'd0, vec_vld, vec_idx}, {27'd0, 1'b1, 4'd0});
    cyc(16'd0, 0, 0, 1, 2'd0, 32'd0, 1);
    idle(1);
    chk("R3 level 5 next", {27'd0, vec_vld, vec_idx}, {27'd0, 1'b1, 4'd5});

    // constrained random
    for (int it = 0; it < 4000; it++) begin
      logic [15:0] rq;
      bit          op, w, p, a;
      logic [1:0]  ad;
      logic [31:0] wd;
      rq = '0;
      if ($urandom_range(0, 4) == 0) rq = 16'd1 << $urandom_range(0, 15);
      if ($urandom_range(0, 19) == 0) rq = 16'($urandom);
      op = ($urandom_range(0, 3) == 0);
      w  = $urandom_range(0, 1) == 1;
      p  = ($urandom_range(0, 7) != 0);
      ad = 2'($urandom_range(0, 3));
      wd = $urandom;
      a  = $urandom_range(0, 1) == 1;
      cyc(rq, op, w, p, ad, wd, a);
    end
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule